// File: doc/BRIEF.md
# Activity-Monitoring Watchdog Reset Generator

This block supervises a microcontroller by watching one of its free-running activity signals rather than waiting for an explicit service write. A static select input picks the signal to watch: the address-latch strobe, the serial data line or one general-purpose port pin. Each input passes through a synchronizer. Every edge seen on the chosen input restarts a timeout counter. If the counter runs out while the watchdog is enabled, the block drives a reset pulse of fixed width to the processor and to the attached peripheral module.

An asynchronous power-on input starts a reset pulse of the same width on both outputs, whatever the enable says. The processor can also request a reset of the peripheral module alone through a single-cycle request strobe, which it raises when it writes to a dedicated address. That request leaves the processor reset untouched. When a watchdog pulse ends, the timeout counter starts from its full value, so the restarted system has a complete window before it must show activity.

Top module: `act_watchdog`

## Requirements
- R1: `srcSel` picks the monitored input: code 0 selects `actStrobe`, code 1 selects `actSerial`, code 2 selects `actPortPin`. Edges on the inputs that are not selected have no effect on the timeout.
- R2: Any edge, rising or falling, on the selected input after a `SYNC_STAGES`-flop synchronizer reloads the timeout counter. An input that toggles at least once every `TIMEOUT-SYNC_STAGES-1` cycles therefore never causes a reset.
- R3: With `wdEnable` high and no edge on the selected input, `cpuReset` and `periphReset` both rise on the `TIMEOUT`-th rising clock edge after the previous reset pulse ended.
- R4: While `porN` is low, both outputs are high. After `porN` rises they fall together on the `PULSE_W`-th rising clock edge, whatever the value of `wdEnable`.
- R5: While `wdEnable` is low, no timeout reset is produced and the counter is held at its full value. After `wdEnable` returns high, a timeout takes exactly `TIMEOUT` edges.
- R6: A watchdog reset pulse lasts exactly `PULSE_W` clock edges on both outputs, whether or not activity resumes during the pulse.
- R7: After a watchdog pulse ends, the next timeout takes a full `TIMEOUT` edges.
- R8: Select code 3 selects no source. While the watchdog is enabled, the timeout then always expires, no matter which inputs toggle.
- R9: When `swPeriphReq` is high at a rising edge, `periphReset` goes high from that edge for `PULSE_W` edges and `cpuReset` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| actStrobe | input | 1 | Address-latch strobe activity candidate (select code 0) |
| actSerial | input | 1 | Serial data activity candidate (select code 1) |
| actPortPin | input | 1 | General port pin activity candidate (select code 2) |
| srcSel | input | 2 | Monitored source select; code 3 selects no source |
| wdEnable | input | 1 | Timeout reset enable |
| swPeriphReq | input | 1 | Single-cycle request for a peripheral-only reset |
| cpuReset | output | 1 | Processor reset, active high |
| periphReset | output | 1 | Peripheral module reset, active high |

## Verification
The bench builds the block with `TIMEOUT=24`, `PULSE_W=5` and two synchronizer stages. With these values every timeout and pulse can be measured to the exact edge. The bench sweeps all four select codes against a toggle on each of the three inputs, which is all twelve pairings. Each fire case is followed through the pulse and into the next full window, and each quiet case is watched for three timeout periods. Short runs cover the disabled watchdog, an enable that drops and returns, and a software peripheral reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    WD_PWR  = 2'd0,
    WD_RUN  = 2'd1,
    WD_FIRE = 2'd2
  } wdState_t;

  typedef struct packed {
    logic loadTimeout;
    logic decTimeout;
    logic loadPulse;
    logic decPulse;
  } ctrlStrobes_t;

  localparam int SEL_W = 2;

endpackage

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int TIMEOUT     = 50000,
  parameter int PULSE_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_SRC     = 3
) (
  input  logic               clk,
  input  logic               porN,
  input  logic [NUM_SRC-1:0] actIn,
  input  logic [SEL_W-1:0]   srcSel,
  input  ctrlStrobes_t       strb,
  input  logic               periphReq,
  output logic               activity,
  output logic               timeZero,
  output logic               pulseZero,
  output logic               periphBusy
);

  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int PW = $clog2(PULSE_W + 1);
  localparam logic [TW-1:0] TIME_RELOAD  = TW'(TIMEOUT - 1);
  localparam logic [PW-1:0] PULSE_RELOAD = PW'(PULSE_W - 1);

  logic [NUM_SRC-1:0] srcEdge;

  // one synchronizer plus edge-detect flop per candidate source
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic [SYNC_STAGES:0] shReg;
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) shReg <= '0;
      else       shReg <= {shReg[SYNC_STAGES-1:0], actIn[g]};
    end
    assign srcEdge[g] = shReg[SYNC_STAGES] ^ shReg[SYNC_STAGES-1];
  end

  // source mux; codes at or beyond NUM_SRC select nothing
  always_comb begin
    activity = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcSel == SEL_W'(i)) activity = srcEdge[i];
    end
  end

  // timeout counter
  logic [TW-1:0] timeCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                timeCnt <= TIME_RELOAD;
    else if (strb.loadTimeout) timeCnt <= TIME_RELOAD;
    else if (strb.decTimeout)  timeCnt <= timeCnt - 1'b1;
  end
  assign timeZero = (timeCnt == '0);

  // processor pulse width counter
  logic [PW-1:0] pulseCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)               pulseCnt <= PULSE_RELOAD;
    else if (strb.loadPulse) pulseCnt <= PULSE_RELOAD;
    else if (strb.decPulse)  pulseCnt <= pulseCnt - 1'b1;
  end
  assign pulseZero = (pulseCnt == '0);

  // independent peripheral-only pulse
  logic [PW-1:0] periphCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      periphCnt  <= '0;
      periphBusy <= 1'b0;
    end else if (periphReq) begin
      periphCnt  <= PULSE_RELOAD;
      periphBusy <= 1'b1;
    end else if (periphBusy) begin
      if (periphCnt == '0) periphBusy <= 1'b0;
      else                 periphCnt  <= periphCnt - 1'b1;
    end
  end

endmodule

// File: rtl/wdg_control.sv
module wdg_control
  import wdg_pkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  logic         wdEnable,
  input  logic         activity,
  input  logic         timeZero,
  input  logic         pulseZero,
  output ctrlStrobes_t strb,
  output logic         cpuReset
);

  wdState_t state, stateNext;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= WD_PWR;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      WD_PWR, WD_FIRE: begin
        if (pulseZero) begin
          stateNext        = WD_RUN;
          strb.loadTimeout = 1'b1;
        end else begin
          strb.decPulse = 1'b1;
        end
      end
      WD_RUN: begin
        if (activity || !wdEnable) begin
          strb.loadTimeout = 1'b1;
        end else if (timeZero) begin
          stateNext      = WD_FIRE;
          strb.loadPulse = 1'b1;
        end else begin
          strb.decTimeout = 1'b1;
        end
      end
      default: stateNext = WD_PWR;
    endcase
  end

  assign cpuReset = (state != WD_RUN);

endmodule

// File: rtl/act_watchdog.sv
module act_watchdog
  import wdg_pkg::*;
#(
  parameter int TIMEOUT     = 50000,
  parameter int PULSE_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             actStrobe,
  input  logic             actSerial,
  input  logic             actPortPin,
  input  logic [SEL_W-1:0] srcSel,
  input  logic             wdEnable,
  input  logic             swPeriphReq,
  output logic             cpuReset,
  output logic             periphReset
);

  localparam int NUM_SRC = 3;

  ctrlStrobes_t strb;
  logic activity, timeZero, pulseZero, periphBusy;

  wdg_datapath #(
    .TIMEOUT(TIMEOUT), .PULSE_W(PULSE_W),
    .SYNC_STAGES(SYNC_STAGES), .NUM_SRC(NUM_SRC)
  ) uDp (
    .clk(clk), .porN(porN),
    .actIn({actPortPin, actSerial, actStrobe}),
    .srcSel(srcSel), .strb(strb), .periphReq(swPeriphReq),
    .activity(activity), .timeZero(timeZero),
    .pulseZero(pulseZero), .periphBusy(periphBusy)
  );

  wdg_control uCtl (
    .clk(clk), .porN(porN), .wdEnable(wdEnable),
    .activity(activity), .timeZero(timeZero), .pulseZero(pulseZero),
    .strb(strb), .cpuReset(cpuReset)
  );

  assign periphReset = cpuReset | periphBusy;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int PULSE_W = 16
) (
  input logic clk,
  input logic porN,
  input logic wdEnable,
  input logic swPeriphReq,
  input logic cpuReset,
  input logic periphReset
);

  localparam int PW = $clog2(PULSE_W + 2);

  // consecutive edges seen with the processor reset high
  logic [PW-1:0] highRun;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)         highRun <= '0;
    else if (cpuReset) highRun <= (highRun == PW'(PULSE_W + 1)) ? highRun : highRun + 1'b1;
    else               highRun <= '0;
  end

  AST_CPU_IMPLIES_PERIPH: assert property (@(posedge clk) disable iff (!porN)
    cpuReset |-> periphReset); // R3

  AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!porN)
    (!wdEnable && !cpuReset) |=> !cpuReset); // R5

  AST_FIRE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!porN)
    $rose(cpuReset) |-> $past(wdEnable)); // R5

  AST_SW_PERIPH_START: assert property (@(posedge clk) disable iff (!porN)
    swPeriphReq |=> periphReset); // R9

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!porN)
    highRun <= PW'(PULSE_W)); // R6

endmodule

bind act_watchdog wdg_checker #(.PULSE_W(PULSE_W)) uChk (
  .clk(clk), .porN(porN), .wdEnable(wdEnable), .swPeriphReq(swPeriphReq),
  .cpuReset(cpuReset), .periphReset(periphReset)
);

// File: tb/act_watchdog_test.sv
module act_watchdog_test;
  localparam int TIMEOUT = 24;
  localparam int PULSE_W = 5;
  localparam int TOG_PER = 8;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic [2:0] actVec = 3'b000;
  logic [1:0] srcSel = 2'd0;
  logic wdEnable = 1'b0;
  logic swPeriphReq = 1'b0;
  logic cpuReset, periphReset;

  int checks = 0;
  int failures = 0;
  int togIdx = -1;
  int togCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  act_watchdog #(.TIMEOUT(TIMEOUT), .PULSE_W(PULSE_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .porN(porN), .actStrobe(actVec[0]), .actSerial(actVec[1]),
    .actPortPin(actVec[2]), .srcSel(srcSel), .wdEnable(wdEnable),
    .swPeriphReq(swPeriphReq), .cpuReset(cpuReset), .periphReset(periphReset)
  );

  // background toggler on one chosen input
  initial forever begin
    @(negedge clk);
    if (togIdx >= 0) begin
      togCnt++;
      if (togCnt % TOG_PER == 0) actVec[togIdx] = ~actVec[togIdx];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic stepEdge();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic countUntilLow(input int maxN, output int n);
    n = 0;
    do begin stepEdge(); n++; end while (cpuReset && n < maxN);
  endtask

  task automatic countUntilHigh(input int maxN, output int n);
    n = 0;
    do begin stepEdge(); n++; end while (!cpuReset && n < maxN);
  endtask

  task automatic powerUp(input logic [1:0] sel, input logic en);
    int n;
    togIdx = -1;
    porN = 1'b0;
    srcSel = sel;
    wdEnable = en;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cpuReset && periphReset, "R4 outputs high in reset", cpuReset, 1);
    porN = 1'b1;
    countUntilLow(100, n);
    check(n == PULSE_W, "R4 power-up pulse width", n, PULSE_W);
  endtask

  initial begin
    int n, m;
    powerUp(2'd0, 1'b0);
    countUntilHigh(4 * TIMEOUT, n);
    check(n == 4 * TIMEOUT && !cpuReset, "R5 no reset while disabled", n, 4 * TIMEOUT);
    check(!periphReset, "R5 periph quiet while disabled", periphReset, 0);

    // sweep every select code against a toggle on each input
    for (int sel = 0; sel < 4; sel++) begin
      for (int t = 0; t < 3; t++) begin
        bit expFire;
        powerUp(2'(sel), 1'b1);
        togCnt = 0;
        togIdx = t;
        expFire = (sel == 3) || (t != sel);
        countUntilHigh(3 * TIMEOUT, n);
        if (expFire) begin
          check(n == TIMEOUT, (sel == 3) ? "R8 invalid select times out" :
                "R1 unselected edges ignored, R3 timeout", n, TIMEOUT);
          check(periphReset, "R3 periph reset with cpu", periphReset, 1);
          countUntilLow(100, m);
          check(m == PULSE_W, "R6 watchdog pulse width", m, PULSE_W);
          countUntilHigh(3 * TIMEOUT, n);
          check(n == TIMEOUT, "R7 full window after pulse", n, TIMEOUT);
        end else begin
          check(n == 3 * TIMEOUT && !cpuReset, "R2 activity holds off reset", n, 3 * TIMEOUT);
          check(!periphReset, "R2 periph quiet under activity", periphReset, 0);
        end
        togIdx = -1;
      end
    end

    // enable dropped partway restarts the window
    powerUp(2'd0, 1'b1);
    repeat (15) stepEdge();
    wdEnable = 1'b0;
    repeat (2) stepEdge();
    wdEnable = 1'b1;
    countUntilHigh(3 * TIMEOUT, n);
    check(n == TIMEOUT, "R5 re-enable gives full window", n, TIMEOUT);

    // software peripheral-only reset
    powerUp(2'd1, 1'b1);
    togCnt = 0;
    togIdx = 1;
    repeat (3) stepEdge();
    swPeriphReq = 1'b1;
    stepEdge();
    swPeriphReq = 1'b0;
    check(periphReset && !cpuReset, "R9 periph rises alone", {periphReset, cpuReset}, 2);
    n = 0;
    m = 0;
    while (periphReset && n < 100) begin
      stepEdge();
      n++;
      if (cpuReset) m++;
    end
    check(n == PULSE_W, "R9 periph pulse width", n, PULSE_W);
    check(m == 0, "R9 cpu untouched", m, 0);
    togIdx = -1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule